// File: doc/BRIEF.md
# Exception Return Frame Unwinder

The block carries out the return step of an exception. When a start request arrives, it takes the current stack pointer and fetches a two-longword exception frame through a 32-bit memory read port. The port uses request/acknowledge handshaking. The first longword is the format word. Its low half becomes the new status register. Two of its bits record how far the stack pointer was misaligned when the frame was pushed. The second longword is the return program counter.

After both reads complete, the block does three things. It restores the saved misalignment into the low bits of the stack pointer. It pops the eight-byte frame. It presents the restored program counter, status register and stack pointer together with a one-cycle done pulse. One cycle later it raises a stack-switch strobe, so that surrounding logic can pick the stack bank that matches the new status register.

Top module: `frame_unwinder`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `stk_switch_o` and `busy_o` are all 0.
- R2: A start accepted while idle issues a read with `rd_addr_o` equal to `sp_i`. The request and its address stay unchanged until a cycle with `rd_ack_i` high.
- R3: After the first read is acknowledged, a second read is issued at `sp_i + 4` (modulo 2^32). It follows in the very next cycle, the two reads never overlap, and no other read is issued during the unwind.
- R4: `sr_o` equals bits 15:0 of the first longword read (the format word).
- R5: `sp_o` equals (`sp_i` OR format-word bits 29:28 placed at bits 1:0) plus 8, modulo 2^32.
- R6: `pc_o` equals the second longword read.
- R7: `done_o` is high for exactly one cycle, the cycle after the second acknowledge, and `pc_o`, `sr_o` and `sp_o` are valid in that cycle. `stk_switch_o` is high for exactly the one cycle after `done_o`.
- R8: `busy_o` is high from the cycle after an accepted start through the strobe cycle. A start request while `busy_o` is high is ignored and does not change the addresses read or the results.
- R9: `rd_ack_i` while `rd_req_o` is low has no effect: no read, no done pulse and no change in outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an exception return (accepted only when idle) |
| sp_i | input | 32 | Current stack pointer, sampled with the accepted start |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 32 | Byte address of the requested longword |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Unwind in progress |
| done_o | output | 1 | One-cycle pulse: restored values valid |
| pc_o | output | 32 | Restored program counter |
| sr_o | output | 16 | Restored status register |
| sp_o | output | 32 | Stack pointer after frame pop |
| stk_switch_o | output | 1 | One-cycle stack-bank switch strobe after done |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of an unwind. It can arrive while a read is stalled, or in the same cycle as an acknowledge, and it must leave both the address sequence and the results unchanged. The bench injects such starts at random cycles of random-latency transfers, and each one carries a different stack pointer. Spurious acknowledges while idle are driven before each unwind, and directed cases cover every misalignment value and stack pointers that wrap across zero.

// File: rtl/unw_pkg.sv
package unw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FMT  = 3'd1,
    ST_PC   = 3'd2,
    ST_DONE = 3'd3,
    ST_SWAP = 3'd4
  } unw_state_e;

  localparam int unsigned LONG_BYTES = 4;
endpackage

// File: rtl/unw_rd_port.sv
// Single-outstanding read requester: request and address held until acknowledged.
module unw_rd_port #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          beat_o,
  output logic [DW-1:0] beat_data_o
);
  assign beat_o      = rd_req_o & rd_ack_i;
  assign beat_data_o = rd_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else if (issue_i) begin
      rd_req_o  <= 1'b1;
      rd_addr_o <= issue_addr_i;
    end else if (beat_o) begin
      rd_req_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/unw_frame_dec.sv
// Pure decode of the format word: status value and repaired, popped stack pointer.
module unw_frame_dec #(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned SR_W        = 16,
  parameter int unsigned ALIGN_LSB   = 28,
  parameter int unsigned ALIGN_W     = 2,
  parameter int unsigned FRAME_BYTES = 8
) (
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   fmt_i,
  output logic [SR_W-1:0] sr_o,
  output logic [AW-1:0]   sp_o
);
  localparam int unsigned PAD_W = AW - ALIGN_W;

  logic [ALIGN_W-1:0] skew;
  logic [AW-1:0]      sp_fixed;

  assign skew     = fmt_i[ALIGN_LSB +: ALIGN_W];
  assign sp_fixed = sp_i | {{PAD_W{1'b0}}, skew};
  assign sp_o     = sp_fixed + AW'(FRAME_BYTES);
  assign sr_o     = fmt_i[SR_W-1:0];
endmodule

// File: rtl/frame_unwinder.sv
module frame_unwinder #(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned SR_W        = 16,
  parameter int unsigned ALIGN_LSB   = 28,
  parameter int unsigned ALIGN_W     = 2,
  parameter int unsigned FRAME_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [AW-1:0]   sp_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_ack_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   pc_o,
  output logic [SR_W-1:0] sr_o,
  output logic [AW-1:0]   sp_o,
  output logic            stk_switch_o
);
  import unw_pkg::*;

  localparam logic [AW-1:0] PC_OFS = AW'(LONG_BYTES);

  unw_state_e     state_q;
  logic [AW-1:0]  sp_q;
  logic [DW-1:0]  fmt_q;
  logic           issue;
  logic [AW-1:0]  issue_addr;
  logic           beat;
  logic [DW-1:0]  beat_data;
  logic [SR_W-1:0] dec_sr;
  logic [AW-1:0]  dec_sp;

  // Request launch: frame word on accepted start, return PC right after it.
  always_comb begin
    issue      = 1'b0;
    issue_addr = sp_q + PC_OFS;
    if (state_q == ST_IDLE && start_i) begin
      issue      = 1'b1;
      issue_addr = sp_i;
    end else if (state_q == ST_FMT && beat) begin
      issue      = 1'b1;
    end
  end

  unw_rd_port #(.AW(AW), .DW(DW)) u_port (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue),
    .issue_addr_i (issue_addr),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .beat_o       (beat),
    .beat_data_o  (beat_data)
  );

  unw_frame_dec #(
    .AW(AW), .DW(DW), .SR_W(SR_W), .ALIGN_LSB(ALIGN_LSB),
    .ALIGN_W(ALIGN_W), .FRAME_BYTES(FRAME_BYTES)
  ) u_dec (
    .sp_i  (sp_q),
    .fmt_i (fmt_q),
    .sr_o  (dec_sr),
    .sp_o  (dec_sp)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      sp_q         <= '0;
      fmt_q        <= '0;
      pc_o         <= '0;
      sr_o         <= '0;
      sp_o         <= '0;
      done_o       <= 1'b0;
      stk_switch_o <= 1'b0;
    end else begin
      done_o       <= 1'b0;
      stk_switch_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sp_q    <= sp_i;
          state_q <= ST_FMT;
        end
        ST_FMT: if (beat) begin
          fmt_q   <= beat_data;
          state_q <= ST_PC;
        end
        ST_PC: if (beat) begin
          pc_o    <= beat_data;
          sr_o    <= dec_sr;
          sp_o    <= dec_sp;
          done_o  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          stk_switch_o <= 1'b1;
          state_q      <= ST_SWAP;
        end
        ST_SWAP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unw_checker.sv
module unw_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          stk_switch_o
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_switch_follows: assert property (@(posedge clk) disable iff (rst)
    done_o |=> stk_switch_o);

  a_r7_switch_has_cause: assert property (@(posedge clk) disable iff (rst)
    stk_switch_o |-> $past(done_o));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!rd_req_o && !done_o && !stk_switch_o));

  a_r3_no_req_at_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !rd_req_o);
endmodule

bind frame_unwinder unw_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_ack_i     (rd_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .stk_switch_o (stk_switch_o)
);

// File: tb/frame_unwinder_tb.sv
module frame_unwinder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] sp_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        busy_o, done_o, stk_switch_o;
  logic [31:0] pc_o, sp_o;
  logic [15:0] sr_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_unwinder u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sp_i(sp_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .pc_o(pc_o), .sr_o(sr_o), .sp_o(sp_o), .stk_switch_o(stk_switch_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sp(input logic [31:0] sp, input logic [31:0] fmt);
    return (sp | {30'd0, fmt[29:28]}) + 32'd8;
  endfunction

  // One full unwind with given latencies; optional mid-flight start pokes (R8).
  task automatic unwind(input logic [31:0] sp, input logic [31:0] fmt,
                        input logic [31:0] pc, input int lat0, input int lat1,
                        input int poke_at);
    int phase = 0;
    int wt = lat0;
    int n = 0;
    bit got = 0;
    bit addr_checked = 0;
    // R9: stray acknowledge while idle
    @(negedge clk);
    rd_ack_i  = 1'b1;
    rd_data_i = 32'hBAD0_BAD0;
    @(negedge clk);
    rd_ack_i = 1'b0;
    chk(!rd_req_o && !done_o && !busy_o, "R9", {29'd0, rd_req_o, done_o, busy_o}, 32'd0);
    start_i = 1'b1;
    sp_i    = sp;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R8 busy", {31'd0, busy_o}, 32'd1);
    while (!got && n < 60) begin
      if (done_o) begin
        got = 1;
        chk(phase == 2, "R7 done timing", phase, 2);
        chk(pc_o == pc, "R6", pc_o, pc);
        chk(sr_o == fmt[15:0], "R4", {16'd0, sr_o}, {16'd0, fmt[15:0]});
        chk(sp_o == exp_sp(sp, fmt), "R5", sp_o, exp_sp(sp, fmt));
        chk(!stk_switch_o, "R7 strobe early", {31'd0, stk_switch_o}, 32'd0);
        @(negedge clk);
        chk(stk_switch_o && !done_o, "R7 strobe", {30'd0, stk_switch_o, done_o}, 32'd2);
        chk(busy_o, "R8 busy in strobe", {31'd0, busy_o}, 32'd1);
        @(negedge clk);
        chk(!stk_switch_o && !busy_o, "R7 strobe width", {30'd0, stk_switch_o, busy_o}, 32'd0);
      end else begin
        rd_ack_i = 1'b0;
        start_i  = (n == poke_at);
        sp_i     = sp ^ 32'h0000_1F00;
        if (rd_req_o) begin
          if (phase >= 2) chk(0, "R3 extra read", rd_addr_o, 32'hFFFF_FFFF);
          else if (!addr_checked) begin
            addr_checked = 1;
            if (phase == 0) chk(rd_addr_o == sp, "R2", rd_addr_o, sp);
            else chk(rd_addr_o == sp + 32'd4, "R3", rd_addr_o, sp + 32'd4);
          end
          if (wt == 0 && phase < 2) begin
            rd_ack_i     = 1'b1;
            rd_data_i    = (phase == 0) ? fmt : pc;
            phase++;
            wt           = lat1;
            addr_checked = 0;
          end else if (wt > 0) wt--;
        end else if (phase == 1) begin
          chk(0, "R3 gap between reads", 32'd0, 32'd1);
        end
        @(negedge clk);
        n++;
      end
    end
    rd_ack_i = 1'b0;
    start_i  = 1'b0;
    if (!got) chk(0, "R7 no done", 32'd0, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!rd_req_o && !done_o && !stk_switch_o && !busy_o, "R1",
        {28'd0, rd_req_o, done_o, stk_switch_o, busy_o}, 32'd0);
    // directed corners
    unwind(32'h0000_1000, 32'h4000_2700, 32'h0000_4000, 0, 0, -1);
    unwind(32'h0000_2004, 32'h7FFF_A5A5, 32'hCAFE_F00D, 0, 0, -1);
    unwind(32'h0000_3008, 32'h1000_0001, 32'h1234_5678, 3, 2, 0);
    unwind(32'h0000_400C, 32'h2000_FFFF, 32'h8765_4320, 1, 4, 1);
    unwind(32'hFFFF_FFF8, 32'hF000_0000, 32'h0000_0002, 2, 0, 2);
    unwind(32'hFFFF_FFFC, 32'h3000_0000, 32'hFFFF_FFFE, 0, 3, 3);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic [31:0] rsp;
      rsp = $urandom & 32'hFFFF_FFFC;
      unwind(rsp, $urandom, $urandom, $urandom_range(0, 4), $urandom_range(0, 4),
             $urandom_range(0, 6) - 1);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule